// File: doc/BRIEF.md
# T3 Alarm-Indication and Idle-Signal Detector

This block sits behind a T3 framer and looks at the payload of each information field. The framer delivers one line bit per accepted cycle. It also marks which bits are overhead bits, which overhead bits are C bits, and the subframe each bit belongs to. The detector compares every field against two reference patterns. The first is a single alternation (1,0,1,0,...). The second is a paired alternation (1,1,0,0,...). Both patterns are re-anchored at the first payload bit after each overhead bit.

A field is accepted as matching when it has fewer than a set number of mismatches against a pattern. Each pattern has its own pair of counters. A set counter counts consecutive matching fields. A clear counter counts consecutive fields that fail the match. A status flag is raised when the set run reaches its length and dropped when the clear run reaches its length. The C bits of each subframe are reduced by a 2-of-3 vote. A vote of one breaks the set run of the alarm indication. For the idle signal, only a vote of one in the idle subframe breaks the set run.

When the framer reports loss of synchronisation, all runs restart and both flags hold their values.

Top module: `t3_ais_idle_det`

## Requirements
- R1: During and after reset, both `ais_o` and `idle_o` are 0.
- R2: `ais_o` becomes 1 at the end of the SET_FIELDS-th consecutive matching field against the single-alternation pattern, provided no C-bit vote of one occurred during that run. Bit k of a field (k = 0 at the first payload bit after an overhead bit) is expected to be 1 when k is even.
- R3: A field matches when its mismatch count is below MM_LIMIT, so MM_LIMIT-1 mismatches still match. A field with MM_LIMIT or more mismatches resets the set run to zero.
- R4: A raised flag drops at the end of the CLR_FIELDS-th consecutive non-matching field for its pattern. A matching field restarts the clear run.
- R5: `idle_o` follows R2 to R4 with the paired-alternation pattern, in which bit k is expected to be 1 when (k/2) is even.
- R6: The C bits of a subframe (overhead bits with `cbit_pos`=1) are decoded by a 2-of-3 majority. A vote of one in any subframe restarts the alarm-indication set run. Only a vote of one with `sub_idx` equal to IDLE_SUB (3) restarts the idle set run. A single one among three C bits restarts neither run.
- R7: A cycle with `sync_lost`=1 restarts every set and clear run and the C-bit vote, and both flags keep their values.
- R8: Cycles with `bit_vld`=0 have no effect, whatever `bit_in` carries. Overhead bits are never compared against the patterns, and payload bits are ignored until the first overhead bit after reset or loss of synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies the line bit and its markers this cycle |
| bit_in | input | 1 | Line bit |
| ovh_bit | input | 1 | Current bit is an overhead bit |
| cbit_pos | input | 1 | Current overhead bit is a C bit |
| sub_idx | input | 3 | Subframe index (1 to 7) of the current bit |
| sync_lost | input | 1 | Framer has lost frame alignment |
| ais_o | output | 1 | Alarm-indication status |
| idle_o | output | 1 | Idle-signal status |

## Verification
The bench builds the detector with 8-bit fields, a mismatch limit of 2, a set run of 6 fields and a clear run of 3. These values make every run boundary reachable in a few dozen cycles. They also allow a sweep over every possible error count in a field, from zero to all eight bits, for both reference patterns. For each swept field the bench counts the mismatches of the sent vector against both patterns by arithmetic and predicts both flags. It also uses C-bit groups placed in different subframes, gaps of invalid cycles, and loss of synchronisation in the middle of set and clear runs.

// File: rtl/t3ai_pkg.sv
package t3ai_pkg;

    localparam int unsigned SUB_W = 3;

    typedef enum logic {
        PAT_ALT  = 1'b0,
        PAT_DALT = 1'b1
    } pat_kind_e;

    typedef struct packed {
        logic evt;
        logic one;
        logic [SUB_W-1:0] sub;
    } cvote_t;

    typedef struct packed {
        logic in_field;
        logic last;
    } fstep_t;

    function automatic logic ref_bit(input pat_kind_e kind, input logic [1:0] pos_lsb);
        return (kind == PAT_ALT) ? ~pos_lsb[0] : ~pos_lsb[1];
    endfunction

endpackage

// File: rtl/t3ai_field_pos.sv
module t3ai_field_pos
    import t3ai_pkg::*;
#(
    parameter int unsigned FIELD_BITS = 84,
    localparam int unsigned PW = $clog2(FIELD_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          vld,
    input  logic          ovh,
    output logic [PW-1:0] pos,
    output fstep_t        step
);
    localparam logic [PW-1:0] OUT_POS  = PW'(FIELD_BITS);
    localparam logic [PW-1:0] LAST_POS = PW'(FIELD_BITS - 1);

    always_comb begin
        step.in_field = vld && !ovh && (pos != OUT_POS);
        step.last     = step.in_field && (pos == LAST_POS);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= OUT_POS;
        end else if (vld && ovh) begin
            pos <= '0;
        end else if (step.in_field) begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/t3ai_cbit_vote.sv
module t3ai_cbit_vote
    import t3ai_pkg::*;
#(
    parameter int unsigned C_PER_SUB = 3,
    localparam int unsigned CW  = $clog2(C_PER_SUB + 1),
    localparam int unsigned MAJ = C_PER_SUB / 2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             strobe,
    input  logic             data,
    input  logic [SUB_W-1:0] sub,
    output cvote_t           vote
);
    logic [CW-1:0] seen;
    logic [CW-1:0] ones;
    logic [CW-1:0] ones_nxt;
    logic          group_end;

    always_comb begin
        ones_nxt  = ones + CW'(data);
        group_end = strobe && (seen == CW'(C_PER_SUB - 1));
        vote.evt  = group_end;
        vote.one  = (ones_nxt >= CW'(MAJ));
        vote.sub  = sub;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || group_end) begin
            seen <= '0;
            ones <= '0;
        end else if (strobe) begin
            seen <= seen + 1'b1;
            ones <= ones_nxt;
        end
    end
endmodule

// File: rtl/t3ai_pattern_det.sv
module t3ai_pattern_det
    import t3ai_pkg::*;
#(
    parameter pat_kind_e   KIND       = PAT_ALT,
    parameter int unsigned FIELD_BITS = 84,
    parameter int unsigned MM_LIMIT   = 4,
    parameter int unsigned SET_FIELDS = 1024,
    parameter int unsigned CLR_FIELDS = 1024,
    localparam int unsigned PW = $clog2(FIELD_BITS + 1),
    localparam int unsigned MW = $clog2(FIELD_BITS + 1),
    localparam int unsigned SW = $clog2(SET_FIELDS + 1),
    localparam int unsigned KW = $clog2(CLR_FIELDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  fstep_t        step,
    input  logic [PW-1:0] pos,
    input  logic          data,
    input  logic          c_bad,
    output logic          flag
);
    logic [MW-1:0] mm;
    logic [MW-1:0] mm_tot;
    logic          miss;
    logic          match;
    logic [SW-1:0] set_cnt;
    logic [KW-1:0] clr_cnt;

    always_comb begin
        miss   = (data != ref_bit(KIND, pos[1:0]));
        mm_tot = ((pos == '0) ? '0 : mm) + MW'(miss);
        match  = (mm_tot < MW'(MM_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mm <= '0;
        end else if (step.in_field) begin
            mm <= mm_tot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_cnt <= '0;
            clr_cnt <= '0;
            flag    <= 1'b0;
        end else if (restart) begin
            set_cnt <= '0;
            clr_cnt <= '0;
        end else if (c_bad) begin
            set_cnt <= '0;
        end else if (step.last) begin
            if (match) begin
                clr_cnt <= '0;
                if (set_cnt != SW'(SET_FIELDS)) set_cnt <= set_cnt + 1'b1;
                if (set_cnt == SW'(SET_FIELDS - 1)) flag <= 1'b1;
            end else begin
                set_cnt <= '0;
                if (clr_cnt != KW'(CLR_FIELDS)) clr_cnt <= clr_cnt + 1'b1;
                if (clr_cnt == KW'(CLR_FIELDS - 1)) flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/t3_ais_idle_det.sv
module t3_ais_idle_det
    import t3ai_pkg::*;
#(
    parameter int unsigned FIELD_BITS = 84,
    parameter int unsigned MM_LIMIT   = 4,
    parameter int unsigned SET_FIELDS = 1024,
    parameter int unsigned CLR_FIELDS = 1024,
    parameter int unsigned C_PER_SUB  = 3,
    parameter int unsigned IDLE_SUB   = 3,
    localparam int unsigned PW = $clog2(FIELD_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       ovh_bit,
    input  logic       cbit_pos,
    input  logic [2:0] sub_idx,
    input  logic       sync_lost,
    output logic       ais_o,
    output logic       idle_o
);
    logic [PW-1:0] pos;
    fstep_t        step;
    cvote_t        vote;
    logic [1:0]    flags;

    t3ai_field_pos #(.FIELD_BITS(FIELD_BITS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .restart (sync_lost),
        .vld     (bit_vld && !sync_lost),
        .ovh     (ovh_bit),
        .pos     (pos),
        .step    (step)
    );

    t3ai_cbit_vote #(.C_PER_SUB(C_PER_SUB)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .restart (sync_lost),
        .strobe  (bit_vld && ovh_bit && cbit_pos && !sync_lost),
        .data    (bit_in),
        .sub     (sub_idx),
        .vote    (vote)
    );

    for (genvar g = 0; g < 2; g++) begin : g_det
        localparam pat_kind_e KIND = (g == 0) ? PAT_ALT : PAT_DALT;
        logic c_bad;
        if (g == 0) begin : g_all_sub
            assign c_bad = vote.evt && vote.one;
        end else begin : g_one_sub
            assign c_bad = vote.evt && vote.one && (vote.sub == SUB_W'(IDLE_SUB));
        end
        t3ai_pattern_det #(
            .KIND       (KIND),
            .FIELD_BITS (FIELD_BITS),
            .MM_LIMIT   (MM_LIMIT),
            .SET_FIELDS (SET_FIELDS),
            .CLR_FIELDS (CLR_FIELDS)
        ) u_det (
            .clk     (clk),
            .rst     (rst),
            .restart (sync_lost),
            .step    (step),
            .pos     (pos),
            .data    (bit_in),
            .c_bad   (c_bad),
            .flag    (flags[g])
        );
    end

    assign ais_o  = flags[0];
    assign idle_o = flags[1];
endmodule

// File: rtl/t3ai_chk.sv
module t3ai_chk (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic ovh_bit,
    input logic sync_lost,
    input logic ais_o,
    input logic idle_o
);
    p_hold_on_sync_r7: assert property (@(posedge clk) disable iff (rst)
        sync_lost |=> ($stable(ais_o) && $stable(idle_o)));

    p_no_move_invalid_r8: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> ($stable(ais_o) && $stable(idle_o)));

    p_no_move_overhead_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && ovh_bit) |=> ($stable(ais_o) && $stable(idle_o)));

    p_ais_rise_on_payload_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_o) |-> $past(bit_vld && !ovh_bit && !sync_lost));

    p_idle_rise_on_payload_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_o) |-> $past(bit_vld && !ovh_bit && !sync_lost));
endmodule

bind t3_ais_idle_det t3ai_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .ovh_bit   (ovh_bit),
    .sync_lost (sync_lost),
    .ais_o     (ais_o),
    .idle_o    (idle_o)
);

// File: tb/sim_t3_ais_idle_det.sv
module sim_t3_ais_idle_det;
    localparam int CLK_PERIOD = 10;
    localparam int FB   = 8;
    localparam int LIM  = 2;
    localparam int SETN = 6;
    localparam int CLRN = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0, bit_in = 1'b0, ovh_bit = 1'b0, cbit_pos = 1'b0, sync_lost = 1'b0;
    logic [2:0] sub_idx = 3'd1;
    logic ais_o, idle_o;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    t3_ais_idle_det #(
        .FIELD_BITS(FB), .MM_LIMIT(LIM), .SET_FIELDS(SETN), .CLR_FIELDS(CLRN),
        .C_PER_SUB(3), .IDLE_SUB(3)
    ) u0 (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .ovh_bit(ovh_bit),
        .cbit_pos(cbit_pos), .sub_idx(sub_idx), .sync_lost(sync_lost),
        .ais_o(ais_o), .idle_o(idle_o)
    );

    function automatic logic ref_of(input int kind, input int k);
        return (kind == 0) ? (k % 2 == 0) : ((k / 2) % 2 == 0);
    endfunction

    function automatic logic [FB-1:0] mkvec(input int kind, input int nerr);
        logic [FB-1:0] v;
        for (int k = 0; k < FB; k++) v[k] = ref_of(kind, k) ^ (k < nerr);
        return v;
    endfunction

    function automatic int count_mm(input logic [FB-1:0] v, input int kind);
        int n = 0;
        for (int k = 0; k < FB; k++) if (v[k] != ref_of(kind, k)) n++;
        return n;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        bit_vld = 1'b0;
        ovh_bit = 1'b0;
        cbit_pos = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_vld = 1'b0; sync_lost = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        bit_vld = 1'b0; sync_lost = 1'b1;
        @(negedge clk);
        sync_lost = 1'b0;
    endtask

    // one overhead bit followed by one information field
    task automatic send_unit(input logic is_c, input logic [2:0] s, input logic cval,
                             input logic [FB-1:0] vec, input bit gaps);
        @(negedge clk);
        bit_vld = 1'b1; ovh_bit = 1'b1; cbit_pos = is_c; sub_idx = s; bit_in = is_c ? cval : 1'b1;
        for (int k = 0; k < FB; k++) begin
            if (gaps) begin
                @(negedge clk);
                bit_vld = 1'b0; ovh_bit = 1'b1; cbit_pos = 1'b1; bit_in = ~vec[k];
            end
            @(negedge clk);
            bit_vld = 1'b1; ovh_bit = 1'b0; cbit_pos = 1'b0; bit_in = vec[k];
        end
    endtask

    task automatic send_n(input int n, input int kind, input int nerr);
        for (int i = 0; i < n; i++) send_unit(1'b0, 3'd1, 1'b0, mkvec(kind, nerr), 1'b0);
    endtask

    task automatic send_cgroup(input logic [2:0] s, input logic [2:0] cv, input int kind);
        for (int i = 0; i < 3; i++) send_unit(1'b1, s, cv[i], mkvec(kind, 0), 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 ais after reset", ais_o, 1'b0);
        check("R1 idle after reset", idle_o, 1'b0);

        // R8: payload before any overhead bit is ignored
        for (int k = 0; k < 3 * FB; k++) begin
            @(negedge clk); bit_vld = 1'b1; ovh_bit = 1'b0; bit_in = ref_of(0, k % FB);
        end
        send_n(SETN - 1, 0, 0);
        settle();
        check("R8 unanchored payload ignored", ais_o, 1'b0);

        // R2: set boundary
        send_n(1, 0, 0);
        settle();
        check("R2 ais after SETN fields", ais_o, 1'b1);
        check("R2 idle stays low on alternating", idle_o, 1'b0);

        // R4: clear run with a restart
        send_n(CLRN - 1, 0, FB);
        send_n(1, 0, 0);
        send_n(CLRN - 1, 0, FB);
        settle();
        check("R4 ais held before clear run done", ais_o, 1'b1);
        send_n(1, 0, FB);
        settle();
        check("R4 ais cleared after CLRN bad fields", ais_o, 1'b0);

        // R3: a failed field restarts the set run
        do_reset();
        send_n(SETN - 1, 0, LIM - 1);
        send_n(1, 0, LIM);
        send_n(SETN - 1, 0, 0);
        settle();
        check("R3 set run restarted by failed field", ais_o, 1'b0);
        send_n(1, 0, LIM - 1);
        settle();
        check("R3 ais after restarted run", ais_o, 1'b1);

        // R3 / R5 sweep over error counts for both patterns
        for (int kind = 0; kind < 2; kind++) begin
            for (int ne = 0; ne <= FB; ne++) begin
                logic [FB-1:0] v = mkvec(kind, ne);
                do_reset();
                for (int i = 0; i < SETN; i++) send_unit(1'b0, 3'd1, 1'b0, v, 1'b0);
                settle();
                check("R3 sweep ais", ais_o, count_mm(v, 0) < LIM);
                check("R5 sweep idle", idle_o, count_mm(v, 1) < LIM);
            end
        end

        // R5: idle set and clear boundaries
        do_reset();
        send_n(SETN - 1, 1, 0);
        settle();
        check("R5 idle before SETN", idle_o, 1'b0);
        send_n(1, 1, 1);
        settle();
        check("R5 idle after SETN", idle_o, 1'b1);
        check("R5 ais stays low on paired pattern", ais_o, 1'b0);
        send_n(CLRN - 1, 1, FB);
        settle();
        check("R5 idle held before clear", idle_o, 1'b1);
        send_n(1, 1, FB);
        settle();
        check("R5 idle cleared", idle_o, 1'b0);

        // R6: majority 1 in subframe 2 restarts ais run
        do_reset();
        send_cgroup(3'd2, 3'b011, 0);
        send_n(SETN - 2, 0, 0);
        settle();
        check("R6 ais run restarted by C vote", ais_o, 1'b0);
        send_n(1, 0, 0);
        settle();
        check("R6 ais after restarted run", ais_o, 1'b1);

        // R6: single one does not restart
        do_reset();
        send_cgroup(3'd2, 3'b001, 0);
        send_n(SETN - 4, 0, 0);
        settle();
        check("R6 ais before run end, single one", ais_o, 1'b0);
        send_n(1, 0, 0);
        settle();
        check("R6 single C one ignored", ais_o, 1'b1);

        // R6: idle ignores subframe 2 votes
        do_reset();
        send_cgroup(3'd2, 3'b111, 1);
        send_n(SETN - 3, 1, 0);
        settle();
        check("R6 idle unaffected by subframe 2", idle_o, 1'b1);

        // R6: idle restarted by subframe 3 vote
        do_reset();
        send_cgroup(3'd3, 3'b111, 1);
        send_n(SETN - 2, 1, 0);
        settle();
        check("R6 idle restarted by subframe 3", idle_o, 1'b0);
        send_n(1, 1, 0);
        settle();
        check("R6 idle after subframe 3 restart", idle_o, 1'b1);

        // R7: sync loss restarts runs, flags hold
        do_reset();
        send_n(3, 0, 0);
        pulse_sync();
        send_n(SETN - 1, 0, 0);
        settle();
        check("R7 set run restarted by sync loss", ais_o, 1'b0);
        send_n(1, 0, 0);
        settle();
        check("R7 ais after run", ais_o, 1'b1);
        send_n(CLRN - 1, 0, FB);
        pulse_sync();
        check("R7 ais held through sync loss", ais_o, 1'b1);
        send_n(CLRN - 1, 0, FB);
        settle();
        check("R7 clear run restarted by sync loss", ais_o, 1'b1);
        send_n(1, 0, FB);
        settle();
        check("R7 ais cleared after full run", ais_o, 1'b0);

        // R8: invalid cycles carrying wrong bits have no effect
        do_reset();
        for (int i = 0; i < SETN; i++) send_unit(1'b0, 3'd1, 1'b0, mkvec(0, 0), 1'b1);
        settle();
        check("R8 gaps ignored", ais_o, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule